// File: doc/BRIEF.md
# Performance Counter Snapshot Controller

This block keeps a bank of running error-event counters and decides when their contents are copied into holding registers that the host reads. It has two modes. In automatic mode, a one-second tick pulse supplied from elsewhere in the chip starts each copy. The host then has the whole second to read the held values before the next copy replaces them. In manual mode the tick has no effect. A copy starts instead on the rising edge of a trigger formed by OR-ing a host control bit with an external update pin. The pin passes through a two-stage synchronizer first.

Every copy does three things. It moves each running count into its holding register. It restarts the running count from the current cycle's event, so no event is dropped or counted twice. It sets a sticky status flag that tells the host fresh values are waiting. The host clears the flag with a strobe, which the register decode raises on a read of the flag or on a write of 1 to it. The running counters stop at all-ones instead of wrapping. A copy completes at most three clock cycles after the trigger edge, which is well inside a 100 ns budget.

Top module: `perf_snap_ctrl`

## Requirements
- R1: After reset every holding register reads 0 and `snap_flag_o` is 0.
- R2: With `man_mode_i` = 0, a cycle with `sec_tick_i` = 1 copies every running count into its holding register and sets `snap_flag_o`. Both are visible after that clock edge. Lane i occupies bits [i*CNT_W +: CNT_W] of `snap_o`.
- R3: Between copies the holding registers do not change, however many events arrive.
- R4: With `man_mode_i` = 1, `sec_tick_i` causes no copy.
- R5: With `man_mode_i` = 1, a 0-to-1 change of (`man_bit_i` OR synchronized `man_pin_i`) causes one copy. A rise of `man_bit_i` takes effect on the next clock edge. A rise of `man_pin_i` takes effect on the third edge that samples it high.
- R6: With `man_mode_i` = 0, rises of `man_bit_i` or `man_pin_i` cause no copy.
- R7: A trigger held high causes only one copy. It must drop and rise again to cause another.
- R8: A copy restarts each running count at 1 if that lane has an event in the copy cycle, and at 0 otherwise.
- R9: A running count holds at 2^CNT_W-1 while further events arrive.
- R10: `flag_clr_i` = 1 clears `snap_flag_o` after the edge. A copy in the same cycle wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse at each one-second boundary |
| man_mode_i | input | 1 | 0 selects automatic copies, 1 selects manual copies |
| man_bit_i | input | 1 | Host manual-copy control bit |
| man_pin_i | input | 1 | Asynchronous external manual-copy pin |
| err_evt_i | input | NUM_CNT | One error event per lane per cycle |
| flag_clr_i | input | 1 | Host clear strobe for the status flag |
| snap_o | output | NUM_CNT*CNT_W | Holding registers, one field per lane |
| snap_flag_o | output | 1 | Sticky flag set by every copy |

## Verification
The automatic-mode tests send different event densities on the two lanes: one lane gets an event every cycle and the other every second cycle. This shows whether the copy places each lane's count in the correct field. Events are also sent in the copy cycle itself, which separates a correct restart at 1 from both a lost event and a double count. In manual mode the tests issue a tick alone, a bit rise, a bit held high, a bit that drops and rises again, and a pin rise. These separate edge detection from level detection and confirm the pin's three-edge latency. A long event burst runs a lane past its maximum, which shows whether the counter saturates or wraps.

// File: rtl/snap_pkg.sv
package snap_pkg;

  typedef enum logic {
    MODE_AUTO   = 1'b0,
    MODE_MANUAL = 1'b1
  } snap_mode_e;

  // Rising-edge detection on a level and its registered copy
  function automatic logic rise_det(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/snap_trig.sv
module snap_trig
  import snap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic tick_i,
  input  logic man_bit_i,
  input  logic man_pin_i,
  output logic man_edge_o,
  output logic xfer_o
);

  logic [SYNC_STAGES-1:0] pin_sync_q;
  logic                   pin_synced;
  logic                   man_or;
  logic                   man_or_q;
  snap_mode_e             mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_sync_q <= '0;
      man_or_q   <= 1'b0;
    end else begin
      pin_sync_q <= {pin_sync_q[SYNC_STAGES-2:0], man_pin_i};
      man_or_q   <= man_or;
    end
  end

  assign pin_synced = pin_sync_q[SYNC_STAGES-1];
  assign man_or     = man_bit_i | pin_synced;
  assign man_edge_o = rise_det(man_or, man_or_q);
  assign mode       = snap_mode_e'(mode_i);

  always_comb begin
    case (mode)
      MODE_MANUAL: xfer_o = man_edge_o;
      default:     xfer_o = tick_i;
    endcase
  end

  // R7
  man_edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    man_edge_o |=> !man_edge_o);

endmodule

// File: rtl/snap_acc.sv
module snap_acc #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] snap_o
);

  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] acc_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == MAXV) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      snap_o <= '0;
    end else if (xfer_i) begin
      snap_o <= acc_q;
      acc_q  <= CNT_W'(evt_i);
    end else if (evt_i) begin
      acc_q  <= sat_inc(acc_q);
    end
  end

  // R2
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |=> snap_o == $past(acc_q));
  // R8
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |=> acc_q == CNT_W'($past(evt_i)));
  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(snap_o));
  // R9
  acc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == MAXV && !xfer_i) |=> acc_q == MAXV);

endmodule

// File: rtl/perf_snap_ctrl.sv
module perf_snap_ctrl #(
  parameter int NUM_CNT     = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sec_tick_i,
  input  logic                     man_mode_i,
  input  logic                     man_bit_i,
  input  logic                     man_pin_i,
  input  logic [NUM_CNT-1:0]       err_evt_i,
  input  logic                     flag_clr_i,
  output logic [NUM_CNT*CNT_W-1:0] snap_o,
  output logic                     snap_flag_o
);

  logic xfer;
  logic man_edge;

  snap_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (man_mode_i),
    .tick_i     (sec_tick_i),
    .man_bit_i  (man_bit_i),
    .man_pin_i  (man_pin_i),
    .man_edge_o (man_edge),
    .xfer_o     (xfer)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
    snap_acc #(.CNT_W(CNT_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (err_evt_i[i]),
      .xfer_i (xfer),
      .snap_o (snap_o[i*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          snap_flag_o <= 1'b0;
    else if (xfer)       snap_flag_o <= 1'b1;
    else if (flag_clr_i) snap_flag_o <= 1'b0;
  end

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> snap_flag_o);
  // R4
  tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (man_mode_i && !man_edge) |-> !xfer);
  // R6
  manual_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_mode_i && !sec_tick_i) |-> !xfer);

endmodule

// File: tb/perf_snap_ctrl_test.sv
module perf_snap_ctrl_test;

  localparam int N    = 2;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick_i = 1'b0, man_mode_i = 1'b0, man_bit_i = 1'b0, man_pin_i = 1'b0;
  logic [N-1:0] err_evt_i = '0;
  logic flag_clr_i = 1'b0;
  logic [N*W-1:0] snap_o;
  logic snap_flag_o;

  perf_snap_ctrl #(.NUM_CNT(N), .CNT_W(W), .SYNC_STAGES(2)) uut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  logic [N*W-1:0] exp_snap_q[$];
  logic           exp_flag_q[$];
  string          tag_q[$];

  // Bench model state, written from the requirements
  int   m_acc[N];
  int   m_snap[N];
  logic m_flag = 1'b0, p1 = 1'b0, p2 = 1'b0, orq = 1'b0;

  task automatic step(input logic tk, input logic md, input logic bt, input logic pn,
                      input logic [N-1:0] ev, input logic cl, input string tag);
    logic or_now, edge_now, xf;
    logic [N*W-1:0] es;
    @(negedge clk);
    sec_tick_i = tk; man_mode_i = md; man_bit_i = bt; man_pin_i = pn;
    err_evt_i = ev; flag_clr_i = cl;
    or_now   = bt | p2;
    edge_now = or_now & ~orq;
    xf       = md ? edge_now : tk;
    for (int i = 0; i < N; i++) begin
      if (xf) begin
        m_snap[i] = m_acc[i];
        m_acc[i]  = ev[i] ? 1 : 0;
      end else if (ev[i] && m_acc[i] < MAXV) begin
        m_acc[i]++;
      end
    end
    if (xf) m_flag = 1'b1;
    else if (cl) m_flag = 1'b0;
    p2 = p1; p1 = pn; orq = or_now;
    for (int i = 0; i < N; i++) es[i*W +: W] = W'(m_snap[i]);
    exp_snap_q.push_back(es);
    exp_flag_q.push_back(m_flag);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares outputs after each edge against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_snap_q.size() > 0) begin
      logic [N*W-1:0] es;
      logic ef;
      string tg;
      es = exp_snap_q.pop_front();
      ef = exp_flag_q.pop_front();
      tg = tag_q.pop_front();
      compared++;
      if (snap_o !== es || snap_flag_o !== ef) begin
        mismatched++;
        $display("FAIL %s: snap=%h flag=%b expected snap=%h flag=%b",
                 tg, snap_o, snap_flag_o, es, ef);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_acc[i] = 0; m_snap[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    compared++;
    if (snap_o !== '0 || snap_flag_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: snap=%h flag=%b expected snap=0 flag=0", snap_o, snap_flag_o);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2/R3: auto mode, lane0 every cycle, lane1 every other cycle
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, {k[0], 1'b1}, 0, "R3");
    // R8: tick with events in the copy cycle
    step(1, 0, 0, 0, 2'b11, 0, "R2_R8");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 2'b10, 0, "R3");
    step(1, 0, 0, 0, 2'b00, 0, "R2");
    // R10: clear flag
    step(0, 0, 0, 0, 2'b01, 1, "R10");
    step(0, 0, 0, 0, 2'b01, 0, "R10");
    // R6: manual bit and pin ignored in auto mode
    step(0, 0, 1, 0, 2'b01, 0, "R6");
    step(0, 0, 0, 1, 2'b00, 0, "R6");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 2'b00, 0, "R6");
    // R10: copy and clear in the same cycle, flag stays set
    step(1, 0, 0, 0, 2'b00, 1, "R10");
    step(0, 0, 0, 0, 2'b11, 1, "R10");

    // R4: manual mode ignores the tick
    step(0, 1, 0, 0, 2'b11, 0, "R4");
    step(1, 1, 0, 0, 2'b01, 0, "R4");
    step(0, 1, 0, 0, 2'b00, 0, "R4");
    // R5: bit rise copies on the next edge
    step(0, 1, 1, 0, 2'b10, 0, "R5");
    // R7: held high does not retrigger
    for (int k = 0; k < 4; k++) step(0, 1, 1, 0, 2'b01, 0, "R7");
    step(0, 1, 0, 0, 2'b00, 0, "R7");
    step(0, 1, 1, 0, 2'b11, 0, "R7");
    step(0, 1, 0, 0, 2'b00, 1, "R7");
    // R5: pin rise copies after the synchronizer
    step(0, 1, 0, 1, 2'b01, 0, "R5");
    for (int k = 0; k < 5; k++) step(0, 1, 0, 1, 2'b01, 0, "R5");
    step(0, 1, 0, 0, 2'b00, 0, "R5");
    for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 2'b00, 0, "R5");

    // R9: saturation past the maximum
    for (int k = 0; k < MAXV + 6; k++) step(0, 0, 0, 0, 2'b01, 0, "R9");
    step(1, 0, 0, 0, 2'b00, 0, "R9");
    step(0, 0, 0, 0, 2'b00, 0, "R9");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule